// File: doc/BRIEF.md
# Staggered Power-Control Sequencer

This block drives three power-control output pins from a single requested power level. The request input is a level: 1 asks for power on and 0 asks for power off. Each time the requested level differs from the level the pins last settled at, the block moves all three pins to the new level.

A mode bit taken from a 32-bit configuration word selects how the pins move. With the mode bit clear, all pins switch together at one clock edge. With the mode bit set, they switch one at a time, a fixed interval apart. On power-up the order is from the lowest pin upward. On power-down the order is reversed.

The interval is 2 ms. It is built from a clock-frequency parameter, so the same block can be used with any system clock. A busy output marks a staggered sequence in progress. A request level that changes during a sequence is picked up once the sequence is complete.

Top module: `pwr_stagger_seq`

## Requirements
- R1: While reset is asserted and at the first clock edge after it, `pwr_en` is 3'b000 and `busy` is 0.
- R2: With `cfg_word[16]` = 0, all three bits of `pwr_en` take the value of `req` at the first clock edge after `req` differs from the settled level, and `busy` stays 0.
- R3: With `cfg_word[16]` = 1, a rise of `req` sets `pwr_en[0]` at the first clock edge. `pwr_en[1]` is set STEP_CYC cycles later and `pwr_en[2]` is set 2*STEP_CYC cycles later.
- R4: With `cfg_word[16]` = 1, a fall of `req` clears `pwr_en[2]` at the first edge, then `pwr_en[1]`, then `pwr_en[0]`, with STEP_CYC cycles between successive changes.
- R5: STEP_CYC equals (CLK_HZ/1000)*STAGGER_MS cycles, which is the 2 ms spacing. No pin changes one cycle before the spacing has elapsed.
- R6: `busy` rises at the edge where the first pin of a staggered sequence changes. It stays high through that sequence and falls at the edge where the last pin changes.
- R7: Changes of `req` during a sequence do not alter that sequence. At the first edge after the sequence ends, a `req` level that differs from the level just reached starts a new sequence.
- R8: Only bit 16 of `cfg_word` has any effect. It is sampled at the edge that starts a sequence, and later changes to it do not affect the running sequence.
- R9: `pwr_en` is always in thermometer form from bit 0 (000, 001, 011 or 111). While `busy` is 0, it is all zeros or all ones.
- R10: While `busy` is 1, at most one bit of `pwr_en` changes per clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration word; bit 16 enables staggering |
| req | input | 1 | Requested power level (1 = on, 0 = off) |
| pwr_en | output | 3 | Registered power-control pins |
| busy | output | 1 | High while a staggered sequence runs |

## Verification
Directed patterns drive power-up and power-down with the mode bit both set and clear. Comparing the two modes separates simultaneous switching from staggered switching. Comparing rise with fall shows whether the reverse order is applied. A probe one cycle before the interval expires catches a spacing that is off by one. A request reversal combined with a mode-bit flip in the middle of a sequence shows that both are held until the sequence ends. The word with every bit except bit 16 set shows that only that bit decodes. A seeded random phase then toggles the request and the configuration word at arbitrary points, including back-to-back sequences, and checks every cycle against a cycle-level reference model.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  localparam int unsigned CFG_WIDTH = 32;

endpackage

// File: rtl/pss_step_timer.sv
module pss_step_timer #(
  parameter int unsigned STEP_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (STEP_CYC < 2) ? 1 : $clog2(STEP_CYC);
  localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && !start && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (run) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pss_seq_ctrl.sv
module pss_seq_ctrl
  import pss_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 3,
  parameter int unsigned ENABLE_BIT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CFG_WIDTH-1:0] cfg_word,
  input  logic                 req,
  input  logic                 tick,
  output logic                 timer_start,
  output logic                 timer_run,
  output logic [NUM_PINS-1:0]  sw_mask,
  output logic                 sw_val,
  output logic                 busy
);
  localparam int unsigned SW = (NUM_PINS < 2) ? 1 : $clog2(NUM_PINS);
  localparam logic [SW-1:0] STEP_LAST = SW'(NUM_PINS - 1);

  seq_state_t    state_q, state_d;
  logic          level_q, level_d;
  logic          dir_q,   dir_d;
  logic [SW-1:0] step_q,  step_d;
  logic          busy_q,  busy_d;

  // Pin picked at a given step: upward when powering on, downward when off.
  function automatic logic [NUM_PINS-1:0] pick_pin(input logic [SW-1:0] s,
                                                    input logic up);
    logic [NUM_PINS-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (up  && (SW'(i) == s))                 m[i] = 1'b1;
      if (!up && (SW'(NUM_PINS - 1 - i) == s))  m[i] = 1'b1;
    end
    return m;
  endfunction

  always_comb begin
    state_d     = state_q;
    level_d     = level_q;
    dir_d       = dir_q;
    step_d      = step_q;
    busy_d      = busy_q;
    timer_start = 1'b0;
    timer_run   = 1'b0;
    sw_mask     = '0;
    sw_val      = dir_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (req != level_q) begin
          sw_val = req;
          if (cfg_word[ENABLE_BIT]) begin
            timer_start = 1'b1;
            sw_mask     = pick_pin('0, req);
            dir_d       = req;
            step_d      = SW'(1);
            busy_d      = 1'b1;
            state_d     = SEQ_RUN;
          end else begin
            sw_mask = '1;
            level_d = req;
          end
        end
      end
      SEQ_RUN: begin
        timer_run = 1'b1;
        if (tick) begin
          sw_mask = pick_pin(step_q, dir_q);
          if (step_q == STEP_LAST) begin
            state_d = SEQ_IDLE;
            busy_d  = 1'b0;
            level_d = dir_q;
            step_d  = '0;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      level_q <= 1'b0;
      dir_q   <= 1'b0;
      step_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      level_q <= level_d;
      dir_q   <= dir_d;
      step_q  <= step_d;
      busy_q  <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/pss_pin_bank.sv
module pss_pin_bank #(
  parameter int unsigned NUM_PINS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] sw_mask,
  input  logic                sw_val,
  output logic [NUM_PINS-1:0] pins
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic pin_q;
    always_ff @(posedge clk) begin
      if (rst)             pin_q <= 1'b0;
      else if (sw_mask[g]) pin_q <= sw_val;
    end
    assign pins[g] = pin_q;
  end
endmodule

// File: rtl/pwr_stagger_seq.sv
module pwr_stagger_seq
  import pss_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 250_000_000,
  parameter int unsigned STAGGER_MS = 2,
  parameter int unsigned NUM_PINS   = 3,
  parameter int unsigned ENABLE_BIT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CFG_WIDTH-1:0] cfg_word,
  input  logic                 req,
  output logic [NUM_PINS-1:0]  pwr_en,
  output logic                 busy
);
  localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
  localparam int unsigned STEP_RAW   = CYC_PER_MS * STAGGER_MS;
  localparam int unsigned STEP_CYC   = (STEP_RAW < 1) ? 1 : STEP_RAW;

  logic                tick;
  logic                timer_start;
  logic                timer_run;
  logic [NUM_PINS-1:0] sw_mask;
  logic                sw_val;

  pss_step_timer #(.STEP_CYC(STEP_CYC)) timer_i (
    .clk   (clk),
    .rst   (rst),
    .start (timer_start),
    .run   (timer_run),
    .tick  (tick)
  );

  pss_seq_ctrl #(.NUM_PINS(NUM_PINS), .ENABLE_BIT(ENABLE_BIT)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_word    (cfg_word),
    .req         (req),
    .tick        (tick),
    .timer_start (timer_start),
    .timer_run   (timer_run),
    .sw_mask     (sw_mask),
    .sw_val      (sw_val),
    .busy        (busy)
  );

  pss_pin_bank #(.NUM_PINS(NUM_PINS)) bank_i (
    .clk     (clk),
    .rst     (rst),
    .sw_mask (sw_mask),
    .sw_val  (sw_val),
    .pins    (pwr_en)
  );
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int unsigned NUM_PINS = 3,
  parameter int unsigned STEP_CYC = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] pins,
  input logic                busy
);
  localparam int unsigned GW = $clog2(STEP_CYC + 2) + 1;
  localparam logic [GW-1:0] GMAX = '1;

  logic [GW-1:0]       gap_q;
  logic [NUM_PINS-1:0] prev_q;

  // Cycles since the last observed pin change, saturating.
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pins;
      if (pins != prev_q)   gap_q <= '0;
      else if (gap_q != GMAX) gap_q <= gap_q + 1'b1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pins == '0 && !busy));

  p_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && (pins != $past(pins))) |-> (gap_q == GW'(STEP_CYC - 1)));

  p_thermometer_r9: assert property (@(posedge clk) disable iff (rst)
    ((pins & (pins + 1'b1)) == '0));

  p_idle_uniform_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (pins == '0 || pins == '1));

  p_single_change_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(pins ^ $past(pins)) <= 1));
endmodule

bind pwr_stagger_seq pss_checker #(.NUM_PINS(NUM_PINS), .STEP_CYC(STEP_CYC)) chk_i (
  .clk  (clk),
  .rst  (rst),
  .pins (pwr_en),
  .busy (busy)
);

// File: tb/pwr_stagger_seq_tb.sv
`timescale 1ns/1ps
module pwr_stagger_seq_tb_top;
  localparam int unsigned CLK_HZ = 8000;
  localparam int unsigned STG_MS = 2;
  localparam int unsigned STEP   = (CLK_HZ / 1000) * STG_MS;
  localparam int unsigned NP     = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        req = 1'b0;
  logic [2:0]  pwr_en;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit model_cmp = 1'b0;

  always #2 clk = ~clk;

  pwr_stagger_seq #(.CLK_HZ(CLK_HZ), .STAGGER_MS(STG_MS), .NUM_PINS(NP)) dut_i (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .req(req),
    .pwr_en(pwr_en), .busy(busy)
  );

  // Cycle-level reference model built from the requirements.
  logic [2:0] m_pins;
  logic       m_busy, m_lvl, m_dir;
  int         m_cnt, m_step;

  function automatic int pin_for(int s, logic up);
    return up ? s : (NP - 1 - s);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pins = '0; m_busy = 0; m_lvl = 0; m_dir = 0; m_cnt = 0; m_step = 0;
    end else if (!m_busy) begin
      if (req != m_lvl) begin
        if (cfg_word[16]) begin
          m_busy = 1; m_dir = req; m_cnt = 0; m_step = 1;
          m_pins[pin_for(0, req)] = req;
        end else begin
          m_pins = {3{req}}; m_lvl = req;
        end
      end
    end else begin
      m_cnt++;
      if (m_cnt == STEP) begin
        m_cnt = 0;
        m_pins[pin_for(m_step, m_dir)] = m_dir;
        if (m_step == NP - 1) begin
          m_busy = 0; m_lvl = m_dir;
        end else begin
          m_step++;
        end
      end
    end
  end

  task automatic check(string tag, logic [2:0] exp_p, logic exp_b);
    checks++;
    if (pwr_en !== exp_p || busy !== exp_b) begin
      fails++;
      $display("FAIL %s: pwr_en=%b busy=%b expected pwr_en=%b busy=%b",
               tag, pwr_en, busy, exp_p, exp_b);
    end
  endtask

  task automatic negs(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  always @(negedge clk) begin
    if (model_cmp) check("R9 random vs model", m_pins, m_busy);
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd5150);
    negs(3);
    check("R1 during reset", 3'b000, 1'b0);
    rst = 1'b0;
    negs(1);
    check("R1 after reset", 3'b000, 1'b0);

    // R2: simultaneous switching
    cfg_word = 32'h0; req = 1'b1; negs(1);
    check("R2 all on together", 3'b111, 1'b0);
    req = 1'b0; negs(1);
    check("R2 all off together", 3'b000, 1'b0);

    // R3/R5/R6: staggered power-up
    cfg_word = 32'h0001_0000; req = 1'b1; negs(1);
    check("R3 pin0 first, R6 busy up", 3'b001, 1'b1);
    negs(STEP - 1);
    check("R5 no change one cycle early", 3'b001, 1'b1);
    negs(1);
    check("R3 pin1 after STEP", 3'b011, 1'b1);
    negs(STEP);
    check("R6 last pin, busy down", 3'b111, 1'b0);

    // R4: staggered power-down
    req = 1'b0; negs(1);
    check("R4 pin2 off first", 3'b011, 1'b1);
    negs(STEP);
    check("R4 pin1 off", 3'b001, 1'b1);
    negs(STEP);
    check("R4 pin0 off last", 3'b000, 1'b0);

    // R7/R8: mid-sequence request and mode changes held off
    req = 1'b1; negs(1);
    check("R7 sequence starts", 3'b001, 1'b1);
    req = 1'b0; cfg_word = 32'h0;
    negs(STEP);
    check("R7 R8 sequence unaffected", 3'b011, 1'b1);
    negs(STEP);
    check("R7 sequence completes", 3'b111, 1'b0);
    negs(1);
    check("R7 pending request served, R8 new mode", 3'b000, 1'b0);

    // R8: other bits decode nothing
    cfg_word = 32'hFFFE_FFFF; req = 1'b1; negs(1);
    check("R8 other bits ignored", 3'b111, 1'b0);
    req = 1'b0; negs(1);
    check("R8 other bits ignored off", 3'b000, 1'b0);

    // Random phase against the model (covers R9/R10 timelines too)
    negs(1);
    model_cmp = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 29) == 0) req = ~req;
      if ($urandom_range(0, 49) == 0)
        cfg_word = {$urandom} ^ ($urandom_range(0, 1) == 0 ? 32'h0001_0000 : 32'h0);
      @(negedge clk);
    end
    model_cmp = 1'b0;
    finish_run();
  end
endmodule